// File: doc/BRIEF.md
# Four-thread barrel processor core

This block is a small processor core that runs several hardware threads by interleaving them at the finest grain. Every clock cycle a different thread gets the issue slot, and the slots are handed out in a fixed rotation that wraps back to thread 0. Each thread owns a program counter and a bank of eight 16-bit general registers, all held in flops inside the core. The pipeline has four stages: fetch, decode with register read, execute with memory access, and writeback. This matches the thread count. As a result, a thread's previous instruction has always left the pipeline before its next one is fetched. The core therefore needs no interlock, stall or bypass logic.

The core has two shared memory ports, one for instructions and one for data. Both are plain request/response ports with a read answered in the same cycle. There is deliberately no ready or back-pressure signal. A memory that could push back would steal slots from unrelated threads and break the fixed issue timing, so the memories must always accept. The instruction port carries a fetch-enable strobe that acts as its valid. Per-thread enable pins let software park a thread without disturbing the others. A debug bus exposes every thread's program counter.

Top module: `barrel_core`

## Requirements
- R1: Synchronous reset loads thread k's program counter with k*32 (parameter STRIDE) and clears every general register of every thread; the first fetch after reset belongs to thread 0.
- R2: Issue slots rotate 0,1,2,3,0,... one per cycle. In each cycle the fetch address equals the program counter of the thread owning that slot. Every thread is fetched exactly once every four cycles, with no stall cycles.
- R3: Instruction fields are opcode [15:13], A [12:10], B [9:7] and C [6:4]. Opcodes 1 (ADD), 2 (SUB) and 3 (AND) write A with B+C, B-C and B&C, each modulo 2^16.
- R4: Opcode 4 (load-immediate) writes A with the zero-extended bits [7:0]. Register 0 always reads as zero, and a write to it is discarded.
- R5: Opcode 5 (load) writes A with data[B+bits[3:0]]. Opcode 6 (store) writes register A to data[B+bits[3:0]]. The data port acts two cycles after the fetch of that instruction, and never reads and writes in the same cycle.
- R6: Opcode 7 (branch-if-zero) sets the thread's PC to PC+sign-extended bits[6:0] when register A is zero, and to PC+1 otherwise. Opcode 0 is a no-op that advances the PC. The thread's next fetch is always on the correct path, so no wrong-path instruction is ever fetched or executed.
- R7: A thread whose enable is low keeps its slot, but the fetch strobe stays low in that slot. Its PC holds, and it makes no register or memory change.
- R8: A thread spinning in an endless loop does not change the slot timing or the results of any other thread.
- R9: Each thread's registers are private: the same register number in two threads holds independent values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| thread_en | input | NT | Per-thread run enable |
| imem_en | output | 1 | Fetch strobe for the current slot |
| imem_addr | output | PCW | Instruction fetch address |
| imem_rdata | input | 16 | Instruction word, valid in the same cycle |
| dmem_we | output | 1 | Data write strobe |
| dmem_re | output | 1 | Data read strobe |
| dmem_addr | output | DAW | Data address |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data, valid in the same cycle |
| dbg_pc | output | NT*PCW | Program counter of every thread, thread k at bits [k*PCW +: PCW] |

## Verification
A fetch is visible on the instruction port in the cycle its slot is active. A load or store reaches the data port two clock edges later. The resulting PC is visible on the debug bus, and as the thread's next fetch address, four edges after the fetch. The bench samples every port at the falling edge. Its slot counter advances once per cycle from the release of reset, so each fetch check lines up with the owning thread. Stores are matched per thread against a queue of expected address and data pairs in program order, and the final PC values are read once every thread has reached its closing loop.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

  localparam int unsigned IW = 16;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_LI   = 3'd4,
    OP_LD   = 3'd5,
    OP_ST   = 3'd6,
    OP_BEQZ = 3'd7
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [2:0] ra;
    logic [2:0] rb;
    logic [2:0] rc;
    logic [7:0] imm;
  } dec_t;

  function automatic dec_t decode(input logic [IW-1:0] w);
    dec_t d;
    d.op  = op_e'(w[15:13]);
    d.ra  = w[12:10];
    d.rb  = w[9:7];
    d.rc  = w[6:4];
    d.imm = w[7:0];
    return d;
  endfunction

endpackage

// File: rtl/barrel_seq.sv
module barrel_seq #(
  parameter int unsigned NT = 4,
  localparam int unsigned TW = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] slot
);

  localparam logic [TW-1:0] LAST = TW'(NT - 1);

  always_ff @(posedge clk) begin
    if (rst)               slot <= '0;
    else if (slot == LAST) slot <= '0;
    else                   slot <= slot + 1'b1;
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (slot != LAST) |=> (slot == $past(slot) + 1'b1)); // R2
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (slot == LAST) |=> (slot == '0)); // R2

endmodule

// File: rtl/barrel_regbank.sv
module barrel_regbank #(
  parameter int unsigned NT   = 4,
  parameter int unsigned XLEN = 16,
  parameter int unsigned NREG = 8,
  localparam int unsigned TW = $clog2(NT),
  localparam int unsigned RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TW-1:0]   rd_tid,
  input  logic [RW-1:0]   ra_idx,
  input  logic [RW-1:0]   rb_idx,
  input  logic [RW-1:0]   rc_idx,
  output logic [XLEN-1:0] ra_val,
  output logic [XLEN-1:0] rb_val,
  output logic [XLEN-1:0] rc_val,
  input  logic            we,
  input  logic [TW-1:0]   wr_tid,
  input  logic [RW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data
);

  logic [XLEN-1:0] bank [NT][NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NT; t++)
        for (int r = 0; r < NREG; r++)
          bank[t][r] <= '0;
    end else if (we && (wr_idx != '0)) begin
      bank[wr_tid][wr_idx] <= wr_data;
    end
  end

  // register 0 is hard-wired to zero on every read port
  assign ra_val = (ra_idx == '0) ? '0 : bank[rd_tid][ra_idx];
  assign rb_val = (rb_idx == '0) ? '0 : bank[rd_tid][rb_idx];
  assign rc_val = (rc_idx == '0) ? '0 : bank[rd_tid][rc_idx];

  // writeback and register read always belong to different threads
  AST_NO_RW_SAME_THREAD: assert property (@(posedge clk) disable iff (rst)
    we |-> (wr_tid != rd_tid)); // R2

endmodule

// File: rtl/barrel_exec.sv
module barrel_exec
  import barrel_pkg::*;
#(
  parameter int unsigned XLEN = 16,
  parameter int unsigned PCW  = 8,
  parameter int unsigned DAW  = 8
) (
  input  op_e             op,
  input  logic [PCW-1:0]  pc,
  input  logic [7:0]      imm,
  input  logic [XLEN-1:0] a_val,
  input  logic [XLEN-1:0] b_val,
  input  logic [XLEN-1:0] c_val,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            wr_en,
  output logic [XLEN-1:0] wr_data,
  output logic            mem_we,
  output logic            mem_re,
  output logic [DAW-1:0]  mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic [PCW-1:0]  next_pc
);

  localparam int unsigned SXW = PCW - 7;

  logic [PCW-1:0] br_off;
  assign br_off    = {{SXW{imm[6]}}, imm[6:0]};
  assign mem_addr  = b_val[DAW-1:0] + DAW'(imm[3:0]);
  assign mem_wdata = a_val;

  always_comb begin
    wr_en   = 1'b0;
    wr_data = '0;
    mem_we  = 1'b0;
    mem_re  = 1'b0;
    next_pc = pc + PCW'(1);
    case (op)
      OP_ADD: begin wr_en = 1'b1; wr_data = b_val + c_val; end
      OP_SUB: begin wr_en = 1'b1; wr_data = b_val - c_val; end
      OP_AND: begin wr_en = 1'b1; wr_data = b_val & c_val; end
      OP_LI:  begin wr_en = 1'b1; wr_data = XLEN'(imm);    end
      OP_LD:  begin wr_en = 1'b1; mem_re = 1'b1; wr_data = mem_rdata; end
      OP_ST:  mem_we = 1'b1;
      OP_BEQZ: if (a_val == '0) next_pc = pc + br_off;
      default: ;
    endcase
  end

endmodule

// File: rtl/barrel_core.sv
module barrel_core
  import barrel_pkg::*;
#(
  parameter int unsigned NT     = 4,
  parameter int unsigned XLEN   = 16,
  parameter int unsigned PCW    = 8,
  parameter int unsigned DAW    = 8,
  parameter int unsigned STRIDE = 32,
  localparam int unsigned TW = $clog2(NT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NT-1:0]     thread_en,
  output logic              imem_en,
  output logic [PCW-1:0]    imem_addr,
  input  logic [IW-1:0]     imem_rdata,
  output logic              dmem_we,
  output logic              dmem_re,
  output logic [DAW-1:0]    dmem_addr,
  output logic [XLEN-1:0]   dmem_wdata,
  input  logic [XLEN-1:0]   dmem_rdata,
  output logic [NT*PCW-1:0] dbg_pc
);

  localparam int unsigned NREG = 8;
  localparam int unsigned RW   = $clog2(NREG);

  // ---------------- sequencer and fetch ----------------
  logic [TW-1:0]  slot;
  logic [PCW-1:0] pc_q [NT];

  barrel_seq #(.NT(NT)) i_seq (
    .clk  (clk),
    .rst  (rst),
    .slot (slot)
  );

  assign imem_addr = pc_q[slot];
  assign imem_en   = thread_en[slot] & ~rst;

  logic            fd_valid;
  logic [TW-1:0]   fd_tid;
  logic [PCW-1:0]  fd_pc;
  logic [IW-1:0]   fd_ir;

  always_ff @(posedge clk) begin
    if (rst) begin
      fd_valid <= 1'b0;
      fd_tid   <= '0;
      fd_pc    <= '0;
      fd_ir    <= '0;
    end else begin
      fd_valid <= imem_en;
      fd_tid   <= slot;
      fd_pc    <= imem_addr;
      fd_ir    <= imem_en ? imem_rdata : '0;
    end
  end

  // ---------------- decode / register read ----------------
  dec_t            dec;
  logic [XLEN-1:0] ra_val, rb_val, rc_val;
  logic            wb_we;
  logic            ew_valid;
  logic [TW-1:0]   ew_tid;
  logic            ew_wen;
  logic [RW-1:0]   ew_widx;
  logic [XLEN-1:0] ew_wdata;
  logic [PCW-1:0]  ew_npc;

  assign dec   = decode(fd_ir);
  assign wb_we = ew_valid & ew_wen;

  barrel_regbank #(.NT(NT), .XLEN(XLEN), .NREG(NREG)) i_regs (
    .clk     (clk),
    .rst     (rst),
    .rd_tid  (fd_tid),
    .ra_idx  (dec.ra),
    .rb_idx  (dec.rb),
    .rc_idx  (dec.rc),
    .ra_val  (ra_val),
    .rb_val  (rb_val),
    .rc_val  (rc_val),
    .we      (wb_we),
    .wr_tid  (ew_tid),
    .wr_idx  (ew_widx),
    .wr_data (ew_wdata)
  );

  logic            de_valid;
  logic [TW-1:0]   de_tid;
  logic [PCW-1:0]  de_pc;
  op_e             de_op;
  logic [RW-1:0]   de_ra;
  logic [7:0]      de_imm;
  logic [XLEN-1:0] de_a, de_b, de_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_valid <= 1'b0;
      de_tid   <= '0;
      de_pc    <= '0;
      de_op    <= OP_NOP;
      de_ra    <= '0;
      de_imm   <= '0;
      de_a     <= '0;
      de_b     <= '0;
      de_c     <= '0;
    end else begin
      de_valid <= fd_valid;
      de_tid   <= fd_tid;
      de_pc    <= fd_pc;
      de_op    <= fd_valid ? dec.op : OP_NOP;
      de_ra    <= dec.ra;
      de_imm   <= dec.imm;
      de_a     <= ra_val;
      de_b     <= rb_val;
      de_c     <= rc_val;
    end
  end

  // ---------------- execute / memory ----------------
  logic            x_wen, x_mwe, x_mre;
  logic [XLEN-1:0] x_wdata;
  logic [PCW-1:0]  x_npc;

  barrel_exec #(.XLEN(XLEN), .PCW(PCW), .DAW(DAW)) i_exec (
    .op        (de_op),
    .pc        (de_pc),
    .imm       (de_imm),
    .a_val     (de_a),
    .b_val     (de_b),
    .c_val     (de_c),
    .mem_rdata (dmem_rdata),
    .wr_en     (x_wen),
    .wr_data   (x_wdata),
    .mem_we    (x_mwe),
    .mem_re    (x_mre),
    .mem_addr  (dmem_addr),
    .mem_wdata (dmem_wdata),
    .next_pc   (x_npc)
  );

  assign dmem_we = de_valid & x_mwe;
  assign dmem_re = de_valid & x_mre;

  always_ff @(posedge clk) begin
    if (rst) begin
      ew_valid <= 1'b0;
      ew_tid   <= '0;
      ew_wen   <= 1'b0;
      ew_widx  <= '0;
      ew_wdata <= '0;
      ew_npc   <= '0;
    end else begin
      ew_valid <= de_valid;
      ew_tid   <= de_tid;
      ew_wen   <= x_wen;
      ew_widx  <= de_ra;
      ew_wdata <= x_wdata;
      ew_npc   <= x_npc;
    end
  end

  // ---------------- writeback: per-thread program counters ----------------
  for (genvar t = 0; t < NT; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst)                                pc_q[t] <= PCW'(t * STRIDE);
      else if (ew_valid && ew_tid == TW'(t))  pc_q[t] <= ew_npc;
    end

    assign dbg_pc[t*PCW +: PCW] = pc_q[t];

    AST_PC_START: assert property (@(posedge clk)
      rst |=> (pc_q[t] == PCW'(t * STRIDE))); // R1
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(ew_valid && ew_tid == TW'(t)) |=> $stable(pc_q[t])); // R7
  end

  // ---------------- pipeline timing properties ----------------
  AST_WB_AHEAD_OF_FETCH: assert property (@(posedge clk) disable iff (rst)
    ew_valid |-> (ew_tid == slot + 1'b1)); // R2
  AST_NEXT_FETCH_PATH: assert property (@(posedge clk) disable iff (rst)
    ew_valid |=> (imem_addr == $past(ew_npc))); // R6
  AST_MEM_ONE_DIR: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re)); // R5
  AST_DISABLED_SLOT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !thread_en[slot] |=> !fd_valid); // R7

endmodule

// File: tb/test_barrel_core.sv
module test_barrel_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  thread_en;
  logic        imem_en;
  logic [7:0]  imem_addr;
  logic [15:0] imem_rdata;
  logic        dmem_we, dmem_re;
  logic [7:0]  dmem_addr;
  logic [15:0] dmem_wdata, dmem_rdata;
  logic [31:0] dbg_pc;

  logic [15:0] imem [256];
  logic [15:0] dmem [256];

  int total = 0;
  int bad   = 0;

  typedef struct {
    int    tid;
    int    addr;
    int    data;
    string req;
  } st_t;
  st_t exp_q[$];

  int mon_slot;
  int mon_found;
  int mon_tid;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_core i_barrel_core (
    .clk        (clk),
    .rst        (rst),
    .thread_en  (thread_en),
    .imem_en    (imem_en),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .dmem_re    (dmem_re),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .dbg_pc     (dbg_pc)
  );

  assign imem_rdata = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_r(input logic [2:0] op, input logic [2:0] a,
                                        input logic [2:0] b, input logic [2:0] c);
    return {op, a, b, c, 4'b0};
  endfunction
  function automatic logic [15:0] enc_li(input logic [2:0] a, input logic [7:0] v);
    return {3'd4, a, 2'b0, v};
  endfunction
  function automatic logic [15:0] enc_m(input logic [2:0] op, input logic [2:0] a,
                                        input logic [2:0] b, input logic [3:0] off);
    return {op, a, b, 3'b0, off};
  endfunction
  function automatic logic [15:0] enc_bz(input logic [2:0] a, input logic [6:0] off);
    return {3'd7, a, 3'b0, off};
  endfunction

  task automatic expect_store(input int tid, input int addr, input int data, input string req);
    st_t e;
    e.tid = tid; e.addr = addr; e.data = data; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic load_programs();
    for (int i = 0; i < 256; i++) begin imem[i] = 16'h0; dmem[i] = 16'h0; end
    // thread 0 at 0: arithmetic, r0, load, branches
    imem[0]  = enc_li(3'd1, 8'h05);
    imem[1]  = enc_li(3'd2, 8'h03);
    imem[2]  = enc_r(3'd1, 3'd3, 3'd1, 3'd2);
    imem[3]  = enc_r(3'd2, 3'd4, 3'd1, 3'd2);
    imem[4]  = enc_r(3'd3, 3'd5, 3'd1, 3'd2);
    imem[5]  = enc_m(3'd6, 3'd3, 3'd0, 4'd0);
    imem[6]  = enc_m(3'd6, 3'd4, 3'd0, 4'd1);
    imem[7]  = enc_m(3'd6, 3'd5, 3'd0, 4'd2);
    imem[8]  = enc_r(3'd1, 3'd0, 3'd1, 3'd2);
    imem[9]  = enc_m(3'd6, 3'd0, 3'd0, 4'd3);
    imem[10] = enc_m(3'd5, 3'd7, 3'd0, 4'd0);
    imem[11] = enc_r(3'd1, 3'd7, 3'd7, 3'd7);
    imem[12] = enc_m(3'd6, 3'd7, 3'd0, 4'd4);
    imem[13] = enc_bz(3'd4, 7'd5);
    imem[14] = enc_bz(3'd0, 7'd2);
    imem[15] = enc_m(3'd6, 3'd1, 3'd0, 4'd5);
    imem[16] = enc_m(3'd6, 3'd2, 3'd0, 4'd6);
    imem[17] = enc_bz(3'd0, 7'd0);
    // thread 1 at 32: same register numbers, other values
    imem[32] = enc_li(3'd1, 8'h10);
    imem[33] = enc_li(3'd3, 8'hAB);
    imem[34] = enc_m(3'd6, 3'd3, 3'd1, 4'd0);
    imem[35] = enc_m(3'd6, 3'd1, 3'd1, 4'd15);
    imem[36] = enc_li(3'd2, 8'hFF);
    imem[37] = enc_r(3'd2, 3'd4, 3'd0, 3'd2);
    imem[38] = enc_m(3'd6, 3'd4, 3'd1, 4'd1);
    imem[39] = enc_bz(3'd0, 7'd0);
    // thread 2 at 64: starts disabled
    imem[64] = enc_li(3'd1, 8'h20);
    imem[65] = enc_li(3'd2, 8'h77);
    imem[66] = enc_m(3'd6, 3'd2, 3'd1, 4'd0);
    imem[67] = enc_m(3'd6, 3'd5, 3'd1, 4'd1);
    imem[68] = enc_bz(3'd0, 7'd0);
    // thread 3 at 96: endless loop from the start
    imem[96] = enc_bz(3'd0, 7'd0);
  endtask

  // fetch-side monitor: slot rotation, disabled slot, looping thread
  always @(negedge clk) begin
    if (rst) begin
      mon_slot = 0;
    end else begin
      if (thread_en[mon_slot]) begin
        chk(imem_en == 1'b1, "R2", "fetch strobe in enabled slot", imem_en, 1);
        chk(imem_addr[6:5] == mon_slot[1:0], "R2", "fetch belongs to slot thread",
            imem_addr, mon_slot * 32);
        if (mon_slot == 3)
          chk(imem_addr == 8'd96, "R8", "looping thread fetch address", imem_addr, 96);
        if (mon_slot == 0)
          chk(imem_addr != 8'd15, "R6", "wrong-path fetch after taken branch", imem_addr, 16);
      end else begin
        chk(imem_en == 1'b0, "R7", "no fetch in disabled slot", imem_en, 0);
        chk(dbg_pc[mon_slot*8 +: 8] == 8'(mon_slot * 32), "R7", "disabled thread PC held",
            dbg_pc[mon_slot*8 +: 8], mon_slot * 32);
      end
      mon_slot = (mon_slot + 1) % 4;
    end
  end

  // data-side monitor: scoreboard of stores, in order per thread
  always @(negedge clk) begin
    if (!rst) begin
      chk(!(dmem_we && dmem_re), "R5", "read and write together", {dmem_we, dmem_re}, 0);
      if (dmem_we) begin
        mon_tid   = int'(dmem_addr[5:4]);
        mon_found = -1;
        for (int i = 0; i < exp_q.size(); i++)
          if (mon_found < 0 && exp_q[i].tid == mon_tid) mon_found = i;
        if (mon_found < 0) begin
          chk(1'b0, "R6", "unexpected store", {dmem_addr, dmem_wdata}, 0);
        end else begin
          chk(dmem_addr == 8'(exp_q[mon_found].addr), exp_q[mon_found].req, "store address",
              dmem_addr, exp_q[mon_found].addr);
          chk(dmem_wdata == 16'(exp_q[mon_found].data), exp_q[mon_found].req, "store data",
              dmem_wdata, exp_q[mon_found].data);
          exp_q.delete(mon_found);
        end
      end
    end
  end

  initial begin
    rst       = 1'b1;
    thread_en = 4'b1011;
    load_programs();
    expect_store(0, 8'h00, 16'h0008, "R3");
    expect_store(0, 8'h01, 16'h0002, "R3");
    expect_store(0, 8'h02, 16'h0001, "R3");
    expect_store(0, 8'h03, 16'h0000, "R4");
    expect_store(0, 8'h04, 16'h0010, "R5");
    expect_store(0, 8'h06, 16'h0003, "R6");
    expect_store(1, 8'h10, 16'h00AB, "R9");
    expect_store(1, 8'h1F, 16'h0010, "R5");
    expect_store(1, 8'h11, 16'hFF01, "R3");
    expect_store(2, 8'h20, 16'h0077, "R7");
    expect_store(2, 8'h21, 16'h0000, "R1");

    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int t = 0; t < 4; t++)
      chk(dbg_pc[t*8 +: 8] == 8'(t * 32), "R1", "reset PC", dbg_pc[t*8 +: 8], t * 32);
    chk(imem_en == 1'b0, "R1", "no fetch in reset", imem_en, 0);

    @(posedge clk); #1 rst = 1'b0;
    repeat (40) @(posedge clk);
    #1 thread_en[2] = 1'b1;
    repeat (160) @(posedge clk);
    @(negedge clk);

    chk(dbg_pc[7:0]   == 8'd17, "R6", "thread 0 final PC", dbg_pc[7:0], 17);
    chk(dbg_pc[15:8]  == 8'd39, "R9", "thread 1 final PC", dbg_pc[15:8], 39);
    chk(dbg_pc[23:16] == 8'd68, "R7", "thread 2 final PC", dbg_pc[23:16], 68);
    chk(dbg_pc[31:24] == 8'd96, "R8", "looping thread PC", dbg_pc[31:24], 96);
    chk(exp_q.size() == 0, "R5", "missing stores", exp_q.size(), 0);
    foreach (exp_q[i])
      $display("FAIL %s missing store: actual=none expected=%0h@%0h",
               exp_q[i].req, exp_q[i].data, exp_q[i].addr);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule